// File: doc/BRIEF.md
# Interleaved Dual-Channel PWM Generator

This block produces high-side and low-side gate enables for two synchronous buck channels. Both channels take their timing from one shared period counter. Each channel compares a digital duty word against its own phase of that counter. The second channel's period starts half a period after the first, so the two channels draw input current at alternating times.

Between any turn-off and the next turn-on of the same channel there is a dead-time gap. A non-zero duty is stretched so that the high-side pulse meets a minimum on-time. The duty is also capped, so the low side gets some time in every period.

Three per-channel controls act on the outputs:
- An overcurrent trip ends the present high-side pulse for the rest of the period.
- A force-low input parks the channel with its low side on.
- A tri-state input turns both drivers of the channel off.

After reset a channel stays tri-stated until its enable input goes high. Each channel outputs a one-cycle start strobe once per period, so that downstream fault counters can count whole switching cycles.

Top module: `dual_pwm_interleave`

## Requirements
- R1: A shared counter runs from 0 to PERIOD-1 and wraps. Channel 0's phase equals the count. Channel 1's phase is the count offset by PERIOD/2, modulo PERIOD. Bit i of `cyc_start` is high during exactly the cycle in which channel i's phase is 0, so each bit pulses once per PERIOD cycles, and bit 1 pulses PERIOD/2 cycles after bit 0.
- R2: Within one channel, `hs_on` and `ls_on` are never high together. After one of them falls, the other rises no sooner than DEAD cycles later.
- R3: A channel loads its duty word only at the edge where its phase is 0. It requests the high side while its phase is below the loaded duty. A duty word changed in the middle of a period has no effect until the next start of that channel's period. With a steady duty D (inside the clamp range) and no faults, each high-side pulse lasts D-DEAD cycles.
- R4: A duty of 0 gives no high-side pulse. A non-zero duty below MIN_ON+DEAD is raised to MIN_ON+DEAD, so the high-side pulse lasts at least MIN_ON cycles.
- R5: A duty above MAX_DUTY is clamped to MAX_DUTY. At that setting, each low-side on-time lasts PERIOD-MAX_DUTY-DEAD cycles.
- R6: If `oc_trip[i]` is sampled high while `hs_on[i]` is high, then `hs_on[i]` is low after that edge and stays low until the next start of that channel's period. `ls_on[i]` follows once the dead time has passed.
- R7: While `force_lo[i]` is high (and tri-state is low), `hs_on[i]` is low from the next edge onward. `ls_on[i]` turns on after the dead time and stays on.
- R8: `tri_st[i]` high, or `ch_en[i]` low, drives both enables of channel i low at the next edge. Tri-state takes priority over force-low.
- R9: Reset clears the counter and all outputs. A channel whose enable has just risen waits DEAD cycles with both enables low before it drives either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | 2 | Per-channel enable; low keeps the channel tri-stated |
| duty_a | input | DW | Duty word for channel 0, in counter ticks |
| duty_b | input | DW | Duty word for channel 1, in counter ticks |
| oc_trip | input | 2 | Per-channel overcurrent terminate |
| force_lo | input | 2 | Per-channel force low side on |
| tri_st | input | 2 | Per-channel tri-state of both drivers |
| hs_on | output | 2 | High-side enables |
| ls_on | output | 2 | Low-side enables |
| cyc_start | output | 2 | Per-channel period-start strobe |

## Verification
Every gate enable is a register. A change on any input is therefore seen at the first clock edge after it is applied. A side that has to wait out the dead time follows DEAD edges after the other side falls. The start strobes are decoded from the counter register, so they are valid during the cycle of phase 0.

The bench drives its inputs and steps its reference model between edges. It compares all outputs half a period after each edge, against the model's state for that edge. On top of this it measures pulse and gap lengths directly, from the run lengths it observes on the outputs.

// File: rtl/dual_pwm_interleave.sv
module dual_pwm_interleave #(
  parameter int PERIOD   = 100,
  parameter int DW       = 8,
  parameter int DEAD     = 2,
  parameter int MIN_ON   = 10,
  parameter int MAX_DUTY = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ch_en,
  input  logic [DW-1:0] duty_a,
  input  logic [DW-1:0] duty_b,
  input  logic [1:0]    oc_trip,
  input  logic [1:0]    force_lo,
  input  logic [1:0]    tri_st,
  output logic [1:0]    hs_on,
  output logic [1:0]    ls_on,
  output logic [1:0]    cyc_start
);
  localparam int HALF    = PERIOD / 2;
  localparam int CW      = $clog2(PERIOD);
  localparam int GW      = $clog2(DEAD + 1);
  localparam int LO_DUTY = MIN_ON + DEAD;

  logic [CW-1:0] cnt;
  logic [CW-1:0] ph [2];
  logic [DW-1:0] din [2];

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (cnt == CW'(PERIOD - 1))  cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  assign ph[0]  = cnt;
  assign ph[1]  = (cnt >= CW'(HALF)) ? cnt - CW'(HALF) : cnt + CW'(PERIOD - HALF);
  assign din[0] = duty_a;
  assign din[1] = duty_b;

  function automatic logic [CW-1:0] clamp_duty(input logic [DW-1:0] d);
    if (d == '0)                 return '0;
    else if (d > DW'(MAX_DUTY))  return CW'(MAX_DUTY);
    else if (d < DW'(LO_DUTY))   return CW'(LO_DUTY);
    else                         return CW'(d);
  endfunction

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic [CW-1:0] dreg, dsel;
    logic [GW-1:0] gap;
    logic          cut, cut_n, want, tgt, hs_q, ls_q, start;

    assign start = (ph[i] == '0);
    assign dsel  = start ? clamp_duty(din[i]) : dreg;
    assign cut_n = start ? 1'b0 : (cut | (oc_trip[i] & hs_q));
    assign want  = (ph[i] < dsel) && !cut_n;
    assign tgt   = want && !force_lo[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dreg <= '0;
        cut  <= 1'b0;
        hs_q <= 1'b0;
        ls_q <= 1'b0;
        gap  <= '0;
      end else begin
        if (start) dreg <= dsel;
        cut <= cut_n;
        if (!ch_en[i] || tri_st[i]) begin
          hs_q <= 1'b0;
          ls_q <= 1'b0;
          gap  <= '0;
        end else if (tgt) begin
          if (ls_q) begin
            ls_q <= 1'b0;
            gap  <= '0;
          end else if (!hs_q) begin
            if (gap >= GW'(DEAD - 1)) hs_q <= 1'b1;
            else                      gap  <= gap + 1'b1;
          end
        end else begin
          if (hs_q) begin
            hs_q <= 1'b0;
            gap  <= '0;
          end else if (!ls_q) begin
            if (gap >= GW'(DEAD - 1)) ls_q <= 1'b1;
            else                      gap  <= gap + 1'b1;
          end
        end
      end
    end

    assign hs_on[i]     = hs_q;
    assign ls_on[i]     = ls_q;
    assign cyc_start[i] = start;
  end
endmodule

// File: rtl/dual_pwm_interleave_chk.sv
module dual_pwm_interleave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ch_en,
  input logic [1:0] oc_trip,
  input logic [1:0] force_lo,
  input logic [1:0] tri_st,
  input logic [1:0] hs_on,
  input logic [1:0] ls_on,
  input logic [1:0] cyc_start
);
  assert_strobe_apart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_start[0] && cyc_start[1]));

  for (genvar i = 0; i < 2; i++) begin : g_a
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_on[i] && ls_on[i]));
    assert_ls_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_on[i]) |-> $past(!hs_on[i]));
    assert_hs_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_on[i]) |-> $past(!ls_on[i]));
    assert_oc_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_trip[i] && hs_on[i]) |=> !hs_on[i]);
    assert_force_hs_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (force_lo[i] && ch_en[i] && !tri_st[i]) |=> !hs_on[i]);
    assert_tristate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tri_st[i] || !ch_en[i]) |=> (!hs_on[i] && !ls_on[i]));
  end
endmodule

bind dual_pwm_interleave dual_pwm_interleave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .oc_trip(oc_trip),
  .force_lo(force_lo), .tri_st(tri_st), .hs_on(hs_on), .ls_on(ls_on),
  .cyc_start(cyc_start)
);

// File: tb/dual_pwm_interleave_tb.sv
module dual_pwm_interleave_tb;
  localparam int PERIOD = 100, DW = 8, DEAD = 2, MIN_ON = 10, MAX_DUTY = 80;
  localparam int HALF = PERIOD / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ch_en = 2'b00, oc_trip = 2'b00, force_lo = 2'b00, tri_st = 2'b00;
  logic [DW-1:0] duty_a = '0, duty_b = '0;
  logic [1:0] hs_on, ls_on, cyc_start;

  always #5 clk = ~clk;

  dual_pwm_interleave #(.PERIOD(PERIOD), .DW(DW), .DEAD(DEAD), .MIN_ON(MIN_ON),
    .MAX_DUTY(MAX_DUTY)) u_dut (.*);

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R9";
  bit done = 0;

  int m_cnt = 0;
  int m_duty [2] = '{0, 0};
  bit m_cut [2] = '{0, 0};
  bit m_hs [2] = '{0, 0};
  bit m_ls [2] = '{0, 0};
  int m_off [2] = '{0, 0};

  int hs_run [2] = '{0, 0}, hs_last [2] = '{0, 0};
  int ls_run [2] = '{0, 0}, ls_last [2] = '{0, 0};
  int hs_seen [2] = '{0, 0}, ls_seen [2] = '{0, 0};
  int s0_cyc = -1, s0_prev = -1, s1_cyc = -1;

  function automatic int phase_of(int c, int ch);
    return ch == 0 ? c : (c + PERIOD - HALF) % PERIOD;
  endfunction

  function automatic int eff_duty(int d);
    if (d == 0) return 0;
    if (d > MAX_DUTY) return MAX_DUTY;
    if (d < MIN_ON + DEAD) return MIN_ON + DEAD;
    return d;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 2; i++) begin
      int ph; bit cutn, go_hi;
      ph = phase_of(m_cnt, i);
      if (!rst_n) begin
        m_duty[i] = 0; m_cut[i] = 0; m_hs[i] = 0; m_ls[i] = 0; m_off[i] = 0;
        continue;
      end
      if (ph == 0) m_duty[i] = eff_duty(int'(i == 0 ? duty_a : duty_b));
      cutn = (ph == 0) ? 1'b0 : (m_cut[i] || (oc_trip[i] && m_hs[i]));
      m_cut[i] = cutn;
      go_hi = (ph < m_duty[i]) && !cutn && !force_lo[i];
      if (!ch_en[i] || tri_st[i]) begin
        m_hs[i] = 0; m_ls[i] = 0; m_off[i] = 0;
      end else if (go_hi ? m_ls[i] : m_hs[i]) begin
        m_hs[i] = 0; m_ls[i] = 0; m_off[i] = 0;
      end else if (!(go_hi ? m_hs[i] : m_ls[i])) begin
        if (m_off[i] + 1 >= DEAD) begin
          if (go_hi) m_hs[i] = 1; else m_ls[i] = 1;
        end else m_off[i]++;
      end
    end
    m_cnt = rst_n ? (m_cnt + 1) % PERIOD : 0;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    cyc++;
    for (int i = 0; i < 2; i++) begin
      check(tag, $sformatf("hs_on[%0d]", i), int'(hs_on[i]), int'(m_hs[i]));
      check(tag, $sformatf("ls_on[%0d]", i), int'(ls_on[i]), int'(m_ls[i]));
      check("R1", $sformatf("cyc_start[%0d]", i), int'(cyc_start[i]),
            int'(phase_of(m_cnt, i) == 0));
      check("R2", $sformatf("overlap ch%0d", i), int'(hs_on[i] && ls_on[i]), 0);
      if (hs_on[i]) begin hs_run[i]++; hs_seen[i]++; end
      else if (hs_run[i] > 0) begin hs_last[i] = hs_run[i]; hs_run[i] = 0; end
      if (ls_on[i]) begin ls_run[i]++; ls_seen[i]++; end
      else if (ls_run[i] > 0) begin ls_last[i] = ls_run[i]; ls_run[i] = 0; end
    end
    if (cyc_start[0]) begin s0_prev = s0_cyc; s0_cyc = cyc; end
    if (cyc_start[1]) s1_cyc = cyc;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic clear_seen();
    for (int i = 0; i < 2; i++) begin hs_seen[i] = 0; ls_seen[i] = 0; end
  endtask

  initial begin
    run(4);
    check("R9", "hs after reset", int'(hs_on), 0);
    check("R9", "ls after reset", int'(ls_on), 0);
    rst_n = 1'b1;
    clear_seen();
    run(30);
    check("R9", "hs while disabled", hs_seen[0] + hs_seen[1], 0);
    check("R9", "ls while disabled", ls_seen[0] + ls_seen[1], 0);

    tag = "R3";
    duty_a = 8'd30; duty_b = 8'd50; ch_en = 2'b11;
    run(3 * PERIOD);
    check("R3", "ch0 pulse length", hs_last[0], 30 - DEAD);
    check("R3", "ch1 pulse length", hs_last[1], 50 - DEAD);
    check("R1", "ch0 period spacing", s0_cyc - s0_prev, PERIOD);
    check("R1", "ch1 offset", (s1_cyc - s0_cyc + PERIOD) % PERIOD, HALF);
    while (!cyc_start[0]) tick();
    run(10);
    duty_a = 8'd60;
    run(PERIOD - 20);
    check("R3", "mid-period duty ignored", hs_last[0], 30 - DEAD);
    run(2 * PERIOD);
    check("R3", "new duty after start", hs_last[0], 60 - DEAD);

    tag = "R4";
    duty_a = 8'd3; duty_b = 8'd0;
    run(2 * PERIOD);
    clear_seen();
    run(PERIOD);
    check("R4", "min on-time pulse", hs_last[0], MIN_ON);
    check("R4", "zero duty no pulse", hs_seen[1], 0);

    tag = "R5";
    duty_a = 8'd200; duty_b = 8'd99;
    run(3 * PERIOD);
    check("R5", "capped pulse ch0", hs_last[0], MAX_DUTY - DEAD);
    check("R5", "capped pulse ch1", hs_last[1], MAX_DUTY - DEAD);
    check("R5", "low-side time ch0", ls_last[0], PERIOD - MAX_DUTY - DEAD);

    tag = "R6";
    duty_a = 8'd40; duty_b = 8'd40;
    run(2 * PERIOD);
    while (!hs_on[0]) tick();
    run(5);
    oc_trip[0] = 1'b1;
    tick();
    oc_trip[0] = 1'b0;
    run(PERIOD);
    check("R6", "cut pulse length", hs_last[0], 6);
    check("R6", "other channel untouched", hs_last[1], 40 - DEAD);
    run(PERIOD);
    check("R6", "pulse restored next period", hs_last[0], 40 - DEAD);

    tag = "R7";
    force_lo[1] = 1'b1;
    run(3);
    clear_seen();
    run(2 * PERIOD);
    check("R7", "forced hs off", hs_seen[1], 0);
    check("R7", "forced ls held", ls_seen[1], 2 * PERIOD);
    force_lo[1] = 1'b0;
    run(2 * PERIOD);

    tag = "R8";
    tri_st[0] = 1'b1; force_lo[0] = 1'b1;
    tick();
    clear_seen();
    run(2 * PERIOD);
    check("R8", "tristate hs", hs_seen[0], 0);
    check("R8", "tristate ls over force", ls_seen[0], 0);
    tri_st[0] = 1'b0; force_lo[0] = 1'b0;
    tag = "R9";
    run(2 * PERIOD);
    ch_en = 2'b00;
    tick();
    clear_seen();
    run(PERIOD);
    check("R9", "disable clears outputs", hs_seen[0] + ls_seen[0] + hs_seen[1] + ls_seen[1], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule